// File: doc/BRIEF.md
# Video Controller Port Command Latch

This block decodes host accesses into the host-port window of a video display processor, in a 24-bit byte address space. It decides which accesses reach the data port, the control port, the beam-position counter or the sound-generator byte. It then issues one strobe for each accepted access to the video core.

Word writes to the control port are sorted two ways. A word can be a direct register load, or it can be one half of a two-word command. A one-bit pending latch records that the first half of a command has arrived. While that latch is set, the next control word is passed on as the second half, even if its upper bits look like a register load. Any access to the data port, and any read of the control port, drops the latch.

Every result is registered. It appears as a one-cycle pulse in the cycle after the clock edge that sampled the access. Read values come from simple input ports: the core's read word, the status word and the vertical and horizontal counters. The block returns them with the same one-cycle latency.

Top module: `vdp_port_front`

## Requirements
- R1: An access is inside the window when address bits 23:21 are 3'b110. It hits a port only if bits 18:16 are also zero. Bits 20:19 and 15:8 are ignored, so the ports are mirrored. Writes outside the window, or to unclaimed offsets inside it, produce no strobe. Reads inside the window always pulse rd_valid, with 0 for unclaimed offsets. Accesses outside the window produce nothing.
- R2: A write to data-port offsets 0x00–0x03 at an even address pulses data_we with the 16-bit word and clears the pending latch.
- R3: A control-port (offsets 0x04–0x07) word write at an even address while the pending latch is set pulses cmd_we with cmd_half=1 and the word, then clears the latch.
- R4: A control-port write while the latch is clear and data bits 15:14 = 2'b10 pulses reg_we. The strobe carries reg_idx = data bits 12:8 and reg_val = data bits 7:0, and the latch stays clear.
- R5: Any other control-port write while the latch is clear pulses cmd_we with cmd_half=0 and the word, and sets the latch.
- R6: A data-port read at an even address pulses data_rd. It returns core_rdata for a word, or core_rdata[15:8] for a byte, and clears the latch. A control-port read returns status_word for a word. A byte read returns status_word[15:8] at an even address and status_word[7:0] at an odd one, and also clears the latch.
- R7: A word access at an odd address in the data or control range is ignored on write. On read it returns 0. The latch is left unchanged either way.
- R8: A byte write (data in bus_wdata[7:0]) at an even offset 0x00–0x07 acts as a word write with the byte in both halves. A byte write at an odd offset there is ignored.
- R9: A word read at offset 0x08 returns {hv_v, hv_h}. Byte reads at 0x08 and 0x09 return hv_v and hv_h.
- R10: A byte write at offset 0x11 pulses psg_we with the byte. A byte read there returns 0.
- R11: After reset all strobes and the latch are 0. Each result is a one-cycle pulse one clock after the sampling edge, and at most one of reg_we, cmd_we, data_we, psg_we and rd_valid is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 24 | Byte address |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_rd | input | 1 | Read strobe (write wins if both set) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data; bytes use bits 7:0 |
| core_rdata | input | 16 | Data-port read word from the video core |
| status_word | input | 16 | Status word returned by control-port reads |
| hv_v | input | 8 | Vertical position counter |
| hv_h | input | 8 | Horizontal position counter |
| reg_we | output | 1 | Register load strobe |
| reg_idx | output | 5 | Register index |
| reg_val | output | 8 | Register value |
| cmd_we | output | 1 | Command word strobe |
| cmd_half | output | 1 | 0 = first half, 1 = second half |
| cmd_word | output | 16 | Command word |
| data_we | output | 1 | Data-port write strobe |
| data_wdata | output | 16 | Data-port write word |
| data_rd | output | 1 | Data-port read strobe to the core |
| psg_we | output | 1 | Sound-generator byte strobe |
| psg_data | output | 8 | Sound-generator byte |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 16 | Read result |
| cmd_pending | output | 1 | Pending latch state |

## Verification
Every strobe, the read result and the updated pending latch are due exactly one clock edge after the edge that samples an access. The driver presents each access at a falling edge and queues what the requirements predict for it. The monitor pops one prediction just after the next rising edge and compares the whole output set at that point. On cycles with nothing queued, the monitor checks that every strobe is low, so a late or stretched pulse is caught.

// File: rtl/vdpf_pkg.sv
package vdpf_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_CTRL,
    SEL_HV,
    SEL_PSG
  } port_sel_e;
endpackage

// File: rtl/vdpf_decode.sv
module vdpf_decode
  import vdpf_pkg::*;
#(
  parameter int            AW        = 24,
  parameter int            OFS_W     = 8,
  parameter logic [AW-1:0] FOLD_MASK = 24'hE700FF,
  parameter logic [AW-1:0] WIN_MASK  = 24'hE00000,
  parameter logic [AW-1:0] WIN_BASE  = 24'hC00000
) (
  input  logic [AW-1:0] addr,
  output logic          in_win,
  output port_sel_e     sel,
  output logic          odd
);
  localparam logic [AW-1:0] OFS_MASK = AW'((1 << OFS_W) - 1);

  logic [AW-1:0]    folded;
  logic [OFS_W-1:0] ofs;
  logic             page_hit;

  always_comb begin
    folded   = addr & FOLD_MASK;
    in_win   = ((addr & WIN_MASK) == WIN_BASE);
    page_hit = ((folded & ~OFS_MASK) == WIN_BASE);
    ofs      = folded[OFS_W-1:0];
    odd      = ofs[0];
    sel      = SEL_NONE;
    if (in_win && page_hit) begin
      if (ofs < OFS_W'(4))                 sel = SEL_DATA;
      else if (ofs < OFS_W'(8))            sel = SEL_CTRL;
      else if (ofs[OFS_W-1:1] == (OFS_W-1)'(4)) sel = SEL_HV;
      else if (ofs == OFS_W'(8'h11))       sel = SEL_PSG;
    end
  end
endmodule

// File: rtl/vdpf_cmd_seq.sv
module vdpf_cmd_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_wr,
  input  logic       port_clear,
  input  logic [1:0] top_bits,
  output logic       reg_hit,
  output logic       first_half,
  output logic       second_half,
  output logic       pending
);
  always_comb begin
    second_half = ctrl_wr && pending;
    reg_hit     = ctrl_wr && !pending && (top_bits == 2'b10);
    first_half  = ctrl_wr && !pending && (top_bits != 2'b10);
  end

  always_ff @(posedge clk) begin
    if (rst)                             pending <= 1'b0;
    else if (first_half)                 pending <= 1'b1;
    else if (second_half || port_clear)  pending <= 1'b0;
  end

  // R5
  first_sets_chk: assert property (@(posedge clk) disable iff (rst)
    first_half |=> pending);
  // R3
  second_clears_chk: assert property (@(posedge clk) disable iff (rst)
    second_half |=> !pending);
  // R6
  port_clear_chk: assert property (@(posedge clk) disable iff (rst)
    port_clear |=> !pending);
  // R4
  reg_keeps_clear_chk: assert property (@(posedge clk) disable iff (rst)
    reg_hit |=> !pending);
endmodule

// File: rtl/vdpf_read_mux.sv
module vdpf_read_mux
  import vdpf_pkg::*;
#(
  parameter int DW = 16
) (
  input  port_sel_e       sel,
  input  logic            odd,
  input  logic            word,
  input  logic [DW-1:0]   core_rdata,
  input  logic [DW-1:0]   status_word,
  input  logic [DW/2-1:0] hv_v,
  input  logic [DW/2-1:0] hv_h,
  output logic [DW-1:0]   rdata
);
  localparam int BW = DW / 2;
  localparam logic [BW-1:0] ZB = '0;

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_DATA: if (!odd) rdata = word ? core_rdata : {ZB, core_rdata[DW-1:BW]};
      SEL_CTRL: begin
        if (word) rdata = odd ? '0 : status_word;
        else      rdata = {ZB, odd ? status_word[BW-1:0] : status_word[DW-1:BW]};
      end
      SEL_HV: begin
        if (word) rdata = odd ? '0 : {hv_v, hv_h};
        else      rdata = {ZB, odd ? hv_h : hv_v};
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/vdp_port_front.sv
module vdp_port_front
  import vdpf_pkg::*;
#(
  parameter int AW  = 24,
  parameter int DW  = 16,
  parameter int RIW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_word,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   core_rdata,
  input  logic [DW-1:0]   status_word,
  input  logic [DW/2-1:0] hv_v,
  input  logic [DW/2-1:0] hv_h,
  output logic            reg_we,
  output logic [RIW-1:0]  reg_idx,
  output logic [DW/2-1:0] reg_val,
  output logic            cmd_we,
  output logic            cmd_half,
  output logic [DW-1:0]   cmd_word,
  output logic            data_we,
  output logic [DW-1:0]   data_wdata,
  output logic            data_rd,
  output logic            psg_we,
  output logic [DW/2-1:0] psg_data,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic            cmd_pending
);
  localparam int BW = DW / 2;

  logic          in_win, odd;
  port_sel_e     sel;
  logic          is_wr, is_rd;
  logic [DW-1:0] wword, rmux;
  logic          data_w, ctrl_w, psg_w, data_r, ctrl_r, clr;
  logic          reg_hit, first_half, second_half;

  vdpf_decode #(.AW(AW)) u_dec (
    .addr(bus_addr), .in_win(in_win), .sel(sel), .odd(odd)
  );

  always_comb begin
    is_wr  = in_win && bus_wr;
    is_rd  = in_win && bus_rd && !bus_wr;
    wword  = bus_word ? bus_wdata : {bus_wdata[BW-1:0], bus_wdata[BW-1:0]};
    data_w = is_wr && (sel == SEL_DATA) && !odd;
    ctrl_w = is_wr && (sel == SEL_CTRL) && !odd;
    psg_w  = is_wr && (sel == SEL_PSG) && !bus_word;
    data_r = is_rd && (sel == SEL_DATA) && !odd;
    ctrl_r = is_rd && (sel == SEL_CTRL) && !(odd && bus_word);
    clr    = data_w || data_r || ctrl_r;
  end

  vdpf_cmd_seq u_seq (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_w), .port_clear(clr),
    .top_bits(wword[DW-1:DW-2]), .reg_hit(reg_hit),
    .first_half(first_half), .second_half(second_half), .pending(cmd_pending)
  );

  vdpf_read_mux #(.DW(DW)) u_rmux (
    .sel(sel), .odd(odd), .word(bus_word), .core_rdata(core_rdata),
    .status_word(status_word), .hv_v(hv_v), .hv_h(hv_h), .rdata(rmux)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_we     <= 1'b0;
      reg_idx    <= '0;
      reg_val    <= '0;
      cmd_we     <= 1'b0;
      cmd_half   <= 1'b0;
      cmd_word   <= '0;
      data_we    <= 1'b0;
      data_wdata <= '0;
      data_rd    <= 1'b0;
      psg_we     <= 1'b0;
      psg_data   <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      reg_we   <= reg_hit;
      cmd_we   <= first_half || second_half;
      data_we  <= data_w;
      data_rd  <= data_r;
      psg_we   <= psg_w;
      rd_valid <= is_rd;
      if (reg_hit) begin
        reg_idx <= wword[BW+RIW-1:BW];
        reg_val <= wword[BW-1:0];
      end
      if (first_half || second_half) begin
        cmd_word <= wword;
        cmd_half <= second_half;
      end
      if (data_w) data_wdata <= wword;
      if (psg_w)  psg_data   <= bus_wdata[BW-1:0];
      if (is_rd)  rd_data    <= rmux;
    end
  end

  // R11
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_we, cmd_we, data_we, psg_we, rd_valid}));
  // R6
  data_rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    data_rd |-> rd_valid);
  // R7
  odd_word_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && in_win && odd && ((sel == SEL_DATA) || (sel == SEL_CTRL)))
      |=> !(data_we || cmd_we || reg_we));
  // R7
  odd_word_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_word && in_win && odd &&
     ((sel == SEL_DATA) || (sel == SEL_CTRL))) |=> $stable(cmd_pending));
  // R1
  outside_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_win |=> !(reg_we || cmd_we || data_we || psg_we || rd_valid));
endmodule

// File: tb/test_vdp_port_front.sv
module test_vdp_port_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] bus_addr = '0;
  logic        bus_word = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] core_rdata = 16'hBEEF;
  logic [15:0] status_word = 16'h3A05;
  logic [7:0]  hv_v = 8'h6C, hv_h = 8'h2D;
  logic        reg_we, cmd_we, cmd_half, data_we, data_rd, psg_we, rd_valid, cmd_pending;
  logic [4:0]  reg_idx;
  logic [7:0]  reg_val, psg_data;
  logic [15:0] cmd_word, data_wdata, rd_data;

  always #2 clk = ~clk;

  vdp_port_front i_vdp_port_front (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_word(bus_word),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .core_rdata(core_rdata), .status_word(status_word), .hv_v(hv_v), .hv_h(hv_h),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_val(reg_val),
    .cmd_we(cmd_we), .cmd_half(cmd_half), .cmd_word(cmd_word),
    .data_we(data_we), .data_wdata(data_wdata), .data_rd(data_rd),
    .psg_we(psg_we), .psg_data(psg_data), .rd_valid(rd_valid),
    .rd_data(rd_data), .cmd_pending(cmd_pending)
  );

  // strobe order: [5] reg [4] cmd [3] data_we [2] psg [1] data_rd [0] rd_valid
  typedef struct {
    string       req;
    logic [5:0]  stb;
    logic        pend;
    logic [15:0] val;
    logic [4:0]  idx;
    logic        half;
  } item_t;

  item_t q[$];
  int    checks = 0, errors = 0;
  logic  m_pend = 1'b0;
  bit    mon_on = 1'b0, done = 1'b0;

  task automatic access(input logic [23:0] a, input bit w, input bit wr,
                        input logic [15:0] d, input string req);
    item_t e;
    bit win, hz, odd;
    logic [7:0]  off;
    logic [15:0] wd;
    @(negedge clk);
    bus_addr = a; bus_word = w; bus_wr = wr; bus_rd = !wr; bus_wdata = d;
    e.req = req; e.stb = '0; e.val = '0; e.idx = '0; e.half = 1'b0;
    win = (a[23:21] == 3'b110); hz = (a[18:16] == 3'b000);
    off = a[7:0]; odd = a[0];
    wd  = w ? d : {d[7:0], d[7:0]};
    if (win) begin
      if (wr) begin
        if (hz && off < 8'd4 && !odd) begin
          e.stb = 6'b001000; e.val = wd; m_pend = 1'b0;
        end else if (hz && off >= 8'd4 && off < 8'd8 && !odd) begin
          if (m_pend) begin
            e.stb = 6'b010000; e.half = 1'b1; e.val = wd; m_pend = 1'b0;
          end else if (wd[15:14] == 2'b10) begin
            e.stb = 6'b100000; e.idx = wd[12:8]; e.val = {8'h00, wd[7:0]};
          end else begin
            e.stb = 6'b010000; e.half = 1'b0; e.val = wd; m_pend = 1'b1;
          end
        end else if (hz && off == 8'h11 && !w) begin
          e.stb = 6'b000100; e.val = {8'h00, d[7:0]};
        end
      end else begin
        e.stb = 6'b000001;
        if (hz && off < 8'd4) begin
          if (!odd) begin
            e.stb = 6'b000011; m_pend = 1'b0;
            e.val = w ? core_rdata : {8'h00, core_rdata[15:8]};
          end
        end else if (hz && off < 8'd8) begin
          if (!(w && odd)) begin
            m_pend = 1'b0;
            e.val = w ? status_word : {8'h00, odd ? status_word[7:0] : status_word[15:8]};
          end
        end else if (hz && off[7:1] == 7'h04) begin
          if (!(w && odd)) e.val = w ? {hv_v, hv_h} : {8'h00, odd ? hv_h : hv_v};
        end
      end
    end
    e.pend = m_pend;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0;
    end
  endtask

  // monitor: results are due one edge after the sampling edge
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      logic [5:0] obs;
      obs = {reg_we, cmd_we, data_we, psg_we, data_rd, rd_valid};
      if (q.size() > 0) begin
        item_t e;
        bit bad;
        e = q.pop_front();
        bad = (obs !== e.stb) || (cmd_pending !== e.pend);
        if (e.stb[5] && (reg_idx !== e.idx || reg_val !== e.val[7:0])) bad = 1'b1;
        if (e.stb[4] && (cmd_word !== e.val || cmd_half !== e.half)) bad = 1'b1;
        if (e.stb[3] && data_wdata !== e.val) bad = 1'b1;
        if (e.stb[2] && psg_data !== e.val[7:0]) bad = 1'b1;
        if (e.stb[0] && rd_data !== e.val) bad = 1'b1;
        checks++;
        if (bad) begin
          errors++;
          $display("FAIL %s: strobes=%b pend=%b reg=%h/%h cmd=%h/%b dw=%h psg=%h rd=%h | expected strobes=%b pend=%b val=%h idx=%h half=%b",
                   e.req, obs, cmd_pending, reg_idx, reg_val, cmd_word, cmd_half,
                   data_wdata, psg_data, rd_data, e.stb, e.pend, e.val, e.idx, e.half);
        end
      end else begin
        checks++;
        if (obs !== 6'b0) begin
          errors++;
          $display("FAIL R11: idle strobes=%b expected 000000", obs);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    checks++; // R11 reset state
    if ({reg_we, cmd_we, data_we, psg_we, data_rd, rd_valid, cmd_pending} !== 7'b0) begin
      errors++;
      $display("FAIL R11: reset outputs=%b expected 0000000",
               {reg_we, cmd_we, data_we, psg_we, data_rd, rd_valid, cmd_pending});
    end
    mon_on = 1'b1;
    // R2 data word write
    access(24'hC00000, 1, 1, 16'h1234, "R2");
    // R4 register load
    access(24'hC00004, 1, 1, 16'h8A55, "R4");
    // R5 first half, then R3 second half that looks like a register load
    access(24'hC00004, 1, 1, 16'h4123, "R5");
    access(24'hC00006, 1, 1, 16'h8F00, "R3");
    // R6 data read cancels pending
    access(24'hC00004, 1, 1, 16'h4000, "R5");
    access(24'hC00002, 1, 0, 16'h0000, "R6");
    // R6 control read cancels pending
    access(24'hC00004, 1, 1, 16'h0011, "R5");
    access(24'hC00004, 1, 0, 16'h0000, "R6");
    // R2 data write cancels pending
    access(24'hC00004, 1, 1, 16'hC0DE, "R5");
    access(24'hC00000, 1, 1, 16'h5A5A, "R2");
    // R7 odd word accesses leave pending set
    access(24'hC00004, 1, 1, 16'h2222, "R5");
    access(24'hC00001, 1, 1, 16'hFFFF, "R7");
    access(24'hC00005, 1, 0, 16'h0000, "R7");
    access(24'hC00003, 1, 0, 16'h0000, "R7");
    access(24'hC00004, 1, 1, 16'h3333, "R3");
    // R8 byte writes
    access(24'hC00004, 0, 1, 16'h0093, "R8");
    access(24'hC00002, 0, 1, 16'h0077, "R8");
    access(24'hC00005, 0, 1, 16'h0012, "R8");
    access(24'hC00006, 0, 1, 16'h0012, "R8");
    access(24'hC00006, 0, 1, 16'h0034, "R8");
    // R1 mirrors and misses
    access(24'hD8AB04, 1, 1, 16'h8701, "R1");
    access(24'hC10000, 1, 1, 16'h1111, "R1");
    access(24'hC10000, 1, 0, 16'h0000, "R1");
    access(24'hE00000, 1, 1, 16'h1111, "R1");
    access(24'hA00000, 1, 0, 16'h0000, "R1");
    access(24'hC8FF00, 1, 0, 16'h0000, "R1");
    // R9 beam counters
    access(24'hC00008, 1, 0, 16'h0000, "R9");
    access(24'hC00008, 0, 0, 16'h0000, "R9");
    access(24'hC00009, 0, 0, 16'h0000, "R9");
    // R10 sound byte
    access(24'hC00011, 0, 1, 16'h009F, "R10");
    access(24'hC00011, 0, 0, 16'h0000, "R10");
    // R6 byte reads
    access(24'hC00004, 1, 1, 16'h0001, "R5");
    access(24'hC00005, 0, 0, 16'h0000, "R6");
    access(24'hC00000, 0, 0, 16'h0000, "R6");
    access(24'hC00001, 0, 0, 16'h0000, "R6");
    idle(4);
    @(posedge clk); #2;
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R11: %0d results missing, expected 0", q.size());
    end
    finish_run();
  end
endmodule